// File: doc/BRIEF.md
# Clock-Correcting Receive Elastic Buffer

This block is a small dual-clock receive FIFO. It sits between a recovered receive clock and a local read clock. The two clocks run at the same nominal rate but come from different sources, so one drifts slightly ahead of the other. One character is written on every write-clock cycle and one is delivered on every read-clock cycle, with no stall on either side. Idle and padding characters pass through exactly like payload.

The read side keeps the fill level near half the depth. It watches the stream for a programmable correction sequence of 1 to 4 characters. If the level drops below half minus two, the read pointer is moved back so that a matched sequence is delivered again. If the level climbs above half plus two, the read pointer jumps past a matched sequence so that it is never delivered. A correction only ever acts on a whole sequence that starts at a sequence boundary. Sticky flags report insertions and removals, and separate flags report when the buffer ran dry or ran full despite correction.

After reset the read side outputs nothing until the buffer has reached half full. From then on it delivers one character per cycle.

Top module: `rx_elastic_buf`

## Requirements
- R1: During reset and after it, `rd_valid_o` and all four flags are 0. `rd_valid_o` first rises only after at least DEPTH/2 characters have been written, and the first character delivered is the first one written.
- R2: When the clock offset is within the correction range, every character outside the correction sequence is delivered exactly once and in write order.
- R3: Correction sequences are delivered only as whole copies: character i of the pattern (`cc_pattern_i[8i+:8]`, character 0 first) is followed by character i+1, up to `cc_len_i` characters.
- R4: When the read clock is faster, a matched sequence is delivered again by moving the read pointer back, and `ins_flag_o` becomes 1 and stays 1. `skip_flag_o` stays 0.
- R5: When the read clock is slower, a matched sequence is dropped by moving the read pointer forward past it, and `skip_flag_o` becomes 1 and stays 1. `ins_flag_o` stays 0.
- R6: When `repeat_wait_i` is 1, or when the sequence length is 1, a sequence is inserted at most once per correction event, so at most two copies appear back to back. When `repeat_wait_i` is 0 and the length is greater than 1, the same sequence may be re-read again while the level is still low.
- R7: With equal clock rates, no correction takes place and both correction flags stay 0.
- R8: Once `rd_valid_o` is 1 it stays 1 until reset, and a character is delivered on every read cycle.
- R9: `unf_flag_o` is set and stays set when the read side reaches the last known write position despite correction. It stays 0 while the clock offset is within the correction range.
- R10: `ovf_flag_o` is set and stays set when the measured fill level reaches DEPTH-2, meaning writes are about to overwrite unread data. It stays 0 while the clock offset is within the correction range.
- R11: `cc_len_i` selects a sequence length of 1 to 4 (a value of 0 is treated as 1, and values above 4 as 4). Correction works for every length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Recovered write clock |
| rclk_i | input | 1 | Local read clock |
| rst_ni | input | 1 | Asynchronous active-low reset, both domains |
| wr_data_i | input | DW | Character written on every write-clock cycle |
| cc_pattern_i | input | MAX_SEQ*DW | Correction pattern, character i at bits [DW*i +: DW] |
| cc_len_i | input | LEN_W | Correction sequence length, 1 to MAX_SEQ |
| repeat_wait_i | input | 1 | 1: one insertion per event; 0: repeated insertion allowed |
| rd_data_o | output | DW | Delivered character (read domain) |
| rd_valid_o | output | 1 | High once reading has started |
| ins_flag_o | output | 1 | Sticky: a sequence was inserted |
| skip_flag_o | output | 1 | Sticky: a sequence was removed |
| ovf_flag_o | output | 1 | Sticky: fill level reached the overflow limit |
| unf_flag_o | output | 1 | Sticky: the read side ran out of data |

## Verification
A wrong pointer move shows up at the read port within one read cycle. It appears as a payload character that is missing, repeated or out of order, or as a payload character that interrupts a partial pattern. A wrong fill-level estimate or threshold is slower to show. It takes a few hundred cycles of drift before it appears as a correction flag of the wrong direction, a flag with equal clocks, or a spurious overflow or underflow flag. A broken repeat rule appears as a third consecutive copy of a sequence the next time the level is low.

// File: rtl/elbuf_pkg.sv
package elbuf_pkg;
  typedef enum logic [1:0] {RD_STEP, RD_SKIP, RD_REWIND} rd_act_e;

  typedef struct packed {
    logic ins;
    logic skip;
    logic ovf;
    logic unf;
  } cc_flags_t;
endpackage

// File: rtl/elbuf_wr.sv
module elbuf_wr #(
  parameter int AW = 4
) (
  input  logic          wclk_i,
  input  logic          rst_ni,
  output logic [AW-1:0] waddr_o,
  output logic [AW:0]   wgray_o
);
  logic [AW:0] wptr_q, wptr_nxt, gray_q;

  assign wptr_nxt = wptr_q + 1'b1;

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      gray_q <= '0;
    end else begin
      wptr_q <= wptr_nxt;
      gray_q <= wptr_nxt ^ (wptr_nxt >> 1);
    end
  end

  assign waddr_o = wptr_q[AW-1:0];
  assign wgray_o = gray_q;

  // R2: crossing pointer changes one bit per write
  a_r2_gray_step: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    1'b1 |=> ($countones(gray_q ^ $past(gray_q)) == 1));
endmodule

// File: rtl/elbuf_sync.sv
module elbuf_sync #(
  parameter int W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] gray_i,
  output logic [W-1:0] bin_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= gray_i;
      s2_q <= s1_q;
    end
  end

  always_comb begin
    logic [W-1:0] b;
    b[W-1] = s2_q[W-1];
    for (int i = W - 2; i >= 0; i--) b[i] = b[i+1] ^ s2_q[i];
    bin_o = b;
  end
endmodule

// File: rtl/elbuf_mem.sv
module elbuf_mem #(
  parameter int DW  = 8,
  parameter int AW  = 4,
  parameter int NRD = 8
) (
  input  logic          wclk_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] rbase_i,
  output logic [DW-1:0] rdata_o [NRD]
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge wclk_i) mem_q[waddr_i] <= wdata_i;

  for (genvar k = 0; k < NRD; k++) begin : g_rd
    logic [AW-1:0] addr;
    assign addr       = rbase_i + AW'(k);
    assign rdata_o[k] = mem_q[addr];
  end
endmodule

// File: rtl/elbuf_rd.sv
module elbuf_rd
  import elbuf_pkg::*;
#(
  parameter int DW      = 8,
  parameter int AW      = 4,
  parameter int MAX_SEQ = 4,
  parameter int LEN_W   = 3,
  parameter int NRD     = 8
) (
  input  logic                  rclk_i,
  input  logic                  rst_ni,
  input  logic [AW:0]           wptr_s_i,
  input  logic [DW-1:0]         rdata_i [NRD],
  input  logic [MAX_SEQ*DW-1:0] cc_pattern_i,
  input  logic [LEN_W-1:0]      cc_len_i,
  input  logic                  repeat_wait_i,
  output logic [AW-1:0]         raddr_o,
  output logic [DW-1:0]         rd_data_o,
  output logic                  rd_valid_o,
  output cc_flags_t             flags_o
);
  localparam int DEPTH = 1 << AW;
  localparam int HALF  = DEPTH / 2;
  localparam logic [AW:0] HALF_C = (AW+1)'(HALF);
  localparam logic [AW:0] LO_C   = (AW+1)'(HALF - 2);
  localparam logic [AW:0] HI_C   = (AW+1)'(HALF + 2);
  localparam logic [AW:0] OVF_C  = (AW+1)'(DEPTH - 2);
  localparam logic [AW:0] FULL_C = (AW+1)'(DEPTH);

  logic [DW-1:0]    pat [MAX_SEQ];
  logic [LEN_W-1:0] len;
  logic [AW:0]      occ, rptr_q, rptr_n, base_q, base_n;
  logic [LEN_W-1:0] rem_q, rem_n;
  logic             started_q, pend_q, pend_n, replay_q, replay_n;
  logic             m0, m1, too_full, too_empty, allow_ins;
  logic [DW-1:0]    out_data, data_q;
  logic             valid_q;
  rd_act_e          act;
  cc_flags_t        flg_q;

  for (genvar i = 0; i < MAX_SEQ; i++) begin : g_pat
    assign pat[i] = cc_pattern_i[i*DW +: DW];
  end

  always_comb begin
    if (cc_len_i == '0)                      len = LEN_W'(1);
    else if (cc_len_i > LEN_W'(MAX_SEQ))     len = LEN_W'(MAX_SEQ);
    else                                     len = cc_len_i;
  end

  assign occ       = wptr_s_i - rptr_q;
  assign too_full  = occ > HI_C;
  assign too_empty = occ < LO_C;
  assign allow_ins = too_empty && !(replay_q && (repeat_wait_i || len == LEN_W'(1)));

  // pattern match at the read pointer and one sequence further on
  always_comb begin
    m0 = 1'b1;
    m1 = 1'b1;
    for (int i = 0; i < MAX_SEQ; i++) begin
      if (i < int'(len)) begin
        if (rdata_i[i] != pat[i])           m0 = 1'b0;
        if (rdata_i[int'(len) + i] != pat[i]) m1 = 1'b0;
      end
    end
  end

  always_comb begin
    act      = RD_STEP;
    rptr_n   = rptr_q + 1'b1;
    rem_n    = rem_q;
    base_n   = base_q;
    pend_n   = pend_q;
    replay_n = replay_q;
    if (!started_q) begin
      rptr_n = rptr_q;
    end else if (rem_q == '0) begin
      replay_n = 1'b0;
      if (m0 && too_full) begin
        act    = RD_SKIP;
        rptr_n = rptr_q + (AW+1)'(len) + 1'b1;
        base_n = rptr_q + (AW+1)'(len);
        rem_n  = m1 ? len - 1'b1 : '0;
        pend_n = 1'b0;
      end else if (m0) begin
        base_n = rptr_q;
        pend_n = 1'b0;
        if (len == LEN_W'(1)) begin
          if (allow_ins) begin
            act      = RD_REWIND;
            rptr_n   = rptr_q;
            replay_n = 1'b1;
          end
        end else begin
          rem_n  = len - 1'b1;
          pend_n = allow_ins;
        end
      end
    end else begin
      rem_n = rem_q - 1'b1;
      if (rem_q == LEN_W'(1) && pend_q) begin
        act      = RD_REWIND;
        rptr_n   = base_q;
        replay_n = 1'b1;
        pend_n   = 1'b0;
      end
    end
  end

  assign out_data = (act == RD_SKIP) ? rdata_i[len] : rdata_i[0];

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      started_q <= 1'b0;
      rptr_q    <= '0;
      base_q    <= '0;
      rem_q     <= '0;
      pend_q    <= 1'b0;
      replay_q  <= 1'b0;
      data_q    <= '0;
      valid_q   <= 1'b0;
      flg_q     <= '0;
    end else begin
      started_q <= started_q | (occ >= HALF_C);
      rptr_q    <= rptr_n;
      base_q    <= base_n;
      rem_q     <= rem_n;
      pend_q    <= pend_n;
      replay_q  <= replay_n;
      valid_q   <= started_q;
      if (started_q) data_q <= out_data;
      flg_q.ins  <= flg_q.ins  | (act == RD_REWIND);
      flg_q.skip <= flg_q.skip | (act == RD_SKIP);
      flg_q.ovf  <= flg_q.ovf  | (started_q && occ >= OVF_C && occ <= FULL_C);
      flg_q.unf  <= flg_q.unf  | (started_q && (occ == '0 || occ > FULL_C));
    end
  end

  assign raddr_o    = rptr_q[AW-1:0];
  assign rd_data_o  = data_q;
  assign rd_valid_o = valid_q;
  assign flags_o    = flg_q;

  // R8: delivery never pauses once started
  a_r8_valid_holds: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    rd_valid_o |=> rd_valid_o);

  // R4: any pointer move other than a single step is a reported correction
  a_r4_jump_flagged: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    started_q |=> (rptr_q == $past(rptr_q) + 1'b1) || flg_q.ins || flg_q.skip);

  // R5: removal only from a level above the window
  a_r5_skip_when_full: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    $rose(flg_q.skip) |-> $past(too_full));

  // R3: sequence progress never exceeds the programmed length
  a_r3_rem_in_len: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    started_q |-> (rem_q < len));
endmodule

// File: rtl/rx_elastic_buf.sv
module rx_elastic_buf
  import elbuf_pkg::*;
#(
  parameter  int DW      = 8,
  parameter  int DEPTH   = 16,
  parameter  int MAX_SEQ = 4,
  localparam int AW      = $clog2(DEPTH),
  localparam int LEN_W   = $clog2(MAX_SEQ + 1)
) (
  input  logic                  wclk_i,
  input  logic                  rclk_i,
  input  logic                  rst_ni,
  input  logic [DW-1:0]         wr_data_i,
  input  logic [MAX_SEQ*DW-1:0] cc_pattern_i,
  input  logic [LEN_W-1:0]      cc_len_i,
  input  logic                  repeat_wait_i,
  output logic [DW-1:0]         rd_data_o,
  output logic                  rd_valid_o,
  output logic                  ins_flag_o,
  output logic                  skip_flag_o,
  output logic                  ovf_flag_o,
  output logic                  unf_flag_o
);
  localparam int NRD = 2 * MAX_SEQ;

  logic [AW-1:0] waddr, raddr;
  logic [AW:0]   wgray, wptr_s;
  logic [DW-1:0] rdata [NRD];
  cc_flags_t     flags;

  elbuf_wr #(.AW(AW)) u_wr (
    .wclk_i (wclk_i),
    .rst_ni (rst_ni),
    .waddr_o(waddr),
    .wgray_o(wgray)
  );

  elbuf_mem #(.DW(DW), .AW(AW), .NRD(NRD)) u_mem (
    .wclk_i (wclk_i),
    .waddr_i(waddr),
    .wdata_i(wr_data_i),
    .rbase_i(raddr),
    .rdata_o(rdata)
  );

  elbuf_sync #(.W(AW + 1)) u_wsync (
    .clk_i (rclk_i),
    .rst_ni(rst_ni),
    .gray_i(wgray),
    .bin_o (wptr_s)
  );

  elbuf_rd #(
    .DW(DW), .AW(AW), .MAX_SEQ(MAX_SEQ), .LEN_W(LEN_W), .NRD(NRD)
  ) u_rd (
    .rclk_i       (rclk_i),
    .rst_ni       (rst_ni),
    .wptr_s_i     (wptr_s),
    .rdata_i      (rdata),
    .cc_pattern_i (cc_pattern_i),
    .cc_len_i     (cc_len_i),
    .repeat_wait_i(repeat_wait_i),
    .raddr_o      (raddr),
    .rd_data_o    (rd_data_o),
    .rd_valid_o   (rd_valid_o),
    .flags_o      (flags)
  );

  assign ins_flag_o  = flags.ins;
  assign skip_flag_o = flags.skip;
  assign ovf_flag_o  = flags.ovf;
  assign unf_flag_o  = flags.unf;
endmodule

// File: tb/rx_elastic_buf_tb_top.sv
`timescale 1ns/1ps
module rx_elastic_buf_tb_top;
  localparam int DW   = 8;
  localparam int HALF = 8;
  localparam int BLK  = 12;

  logic        wclk = 1'b0, rclk = 1'b0, rst_n = 1'b0;
  logic [7:0]  wr_data = '0;
  logic [31:0] cc_pattern = '0;
  logic [2:0]  cc_len = 3'd1;
  logic        repeat_wait = 1'b1;
  logic [7:0]  rd_data;
  logic        rd_valid, ins_f, skip_f, ovf_f, unf_f;

  realtime rhalf = 10.0;
  always #10 wclk = ~wclk;
  initial begin
    #3;
    forever #(rhalf) rclk = ~rclk;
  end

  rx_elastic_buf #(.DW(DW), .DEPTH(16), .MAX_SEQ(4)) dut_i (
    .wclk_i(wclk), .rclk_i(rclk), .rst_ni(rst_n),
    .wr_data_i(wr_data), .cc_pattern_i(cc_pattern), .cc_len_i(cc_len),
    .repeat_wait_i(repeat_wait), .rd_data_o(rd_data), .rd_valid_o(rd_valid),
    .ins_flag_o(ins_f), .skip_flag_o(skip_f), .ovf_flag_o(ovf_f), .unf_flag_o(unf_f)
  );

  int checks = 0, errors = 0;
  logic [7:0] q[$];
  logic [7:0] pat [4];
  int  len = 1, p = 0, k = 0, n_wr = 0;
  bit  chk_data = 0, lim_rep = 0, done = 0;
  int  seq_pos = 0, copies = 0, total_seqs = 0;
  bit  seen_valid = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic present();
    if (k < BLK) begin
      wr_data = 8'(p);
      q.push_back(8'(p));
      p = (p + 1) % 128;
    end else begin
      wr_data = pat[k-BLK];
    end
    k = (k + 1) % (BLK + len);
    n_wr++;
  endtask

  // monitor / scoreboard
  always @(negedge rclk) begin
    if (!rst_n) begin
      seq_pos = 0; copies = 0; seen_valid = 0; total_seqs = 0;
    end else if (rd_valid) begin
      if (!seen_valid) begin
        seen_valid = 1;
        check(n_wr > HALF && n_wr <= HALF + 8, "R1 start level", n_wr, HALF);
        if (chk_data) check(rd_data == 8'd0, "R1 first char", rd_data, 0);
      end
      if (chk_data) begin
        if (rd_data[7]) begin
          check(rd_data == pat[seq_pos], "R3 sequence char", rd_data, pat[seq_pos]);
          seq_pos++;
          if (seq_pos >= len) begin
            seq_pos = 0; copies++; total_seqs++;
          end
        end else begin
          check(seq_pos == 0, "R3 split sequence", seq_pos, 0);
          if (lim_rep) check(copies <= 2, "R6 repeat limit", copies, 2);
          copies = 0; seq_pos = 0;
          if (q.size() == 0) check(0, "R2 unexpected char", rd_data, -1);
          else begin
            logic [7:0] e;
            e = q.pop_front();
            check(rd_data == e, "R2 payload order", rd_data, e);
          end
        end
      end
    end else if (seen_valid) begin
      check(0, "R8 valid dropped", 0, 1);
    end
  end

  task automatic run_phase(input int l, input bit w, input real rh, input logic [7:0] p0,
                           input int ncyc, input bit cd, input bit lr);
    rst_n = 0;
    chk_data = cd; lim_rep = lr;
    len = l; cc_len = 3'(l); repeat_wait = w;
    pat[0] = p0; pat[1] = 8'hB5; pat[2] = 8'hC5; pat[3] = 8'hD5;
    cc_pattern = {pat[3], pat[2], pat[1], pat[0]};
    rhalf = rh;
    q.delete(); n_wr = 0; p = 0; k = 0; wr_data = '0;
    repeat (6) @(negedge wclk);
    check({rd_valid, ins_f, skip_f, ovf_f, unf_f} == 5'b0, "R1 reset state",
          {rd_valid, ins_f, skip_f, ovf_f, unf_f}, 0);
    @(negedge wclk);
    rst_n = 1;
    present();
    repeat (ncyc) begin
      @(negedge wclk);
      present();
    end
    @(negedge rclk);
  endtask

  initial begin
    // A: fast read, length 2, single insertion per event
    run_phase(2, 1'b1, 9.9, 8'hBC, 3000, 1, 1);
    check(ins_f == 1'b1, "R4 ins flag", ins_f, 1);
    check(skip_f == 1'b0, "R4 no skip", skip_f, 0);
    check(ovf_f == 1'b0, "R10 no overflow", ovf_f, 0);
    check(unf_f == 1'b0, "R9 no underflow", unf_f, 0);
    // B: slow read, length 1, other pattern
    run_phase(1, 1'b1, 10.1, 8'h9C, 3000, 1, 1);
    check(skip_f == 1'b1, "R5 skip flag", skip_f, 1);
    check(ins_f == 1'b0, "R5 no ins", ins_f, 0);
    check(ovf_f == 1'b0 && unf_f == 1'b0, "R9 R10 no error flags", {ovf_f, unf_f}, 0);
    // C: faster read, length 4, repeats allowed
    run_phase(4, 1'b0, 9.7, 8'hBC, 3000, 1, 0);
    check(ins_f == 1'b1, "R11 len4 ins flag", ins_f, 1);
    check(total_seqs > 0, "R11 len4 sequences seen", total_seqs, 1);
    check(ovf_f == 1'b0 && unf_f == 1'b0, "R6 repeat without error", {ovf_f, unf_f}, 0);
    // D: equal rates, length 3
    run_phase(3, 1'b1, 10.0, 8'hBC, 3000, 1, 1);
    check(ins_f == 1'b0 && skip_f == 1'b0, "R7 no correction", {ins_f, skip_f}, 0);
    check(total_seqs > 0, "R11 len3 sequences seen", total_seqs, 1);
    // E: read far too fast
    run_phase(1, 1'b1, 8.0, 8'hBC, 3000, 0, 0);
    check(unf_f == 1'b1, "R9 underflow flag", unf_f, 1);
    // F: read far too slow
    run_phase(1, 1'b1, 13.0, 8'hBC, 3000, 0, 0);
    check(ovf_f == 1'b1, "R10 overflow flag", ovf_f, 1);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule